// File: doc/BRIEF.md
# Receive Preamble Detector and Splitter

This block sits on the byte-wide receive stream of an optical network unit, directly after the physical layer. It counts the bytes of each burst while the receive-valid strobe is high. It compares the five fixed leading bytes of the 8-byte point-to-multipoint preamble against a known prefix, and raises a detect flag when all five match. The first eight bytes of every burst go into a private 8-entry buffer. Every byte after them leaves unchanged on a payload port.

When a burst has a confirmed prefix and its eighth byte has been stored, the block replays the stored bytes from the logical-link delimiter through the two link-identifier bytes. These five bytes go to a downstream header-CRC checker, one per cycle, with a valid strobe and a last-byte flag. Computing the CRC, filtering by link identifier and handing frames to the MAC are done elsewhere.

Both outgoing streams carry valid only, with no ready. The physical layer delivers one byte per cycle and cannot be stalled. Adding back-pressure would therefore need buffering at the edge, which this block does not provide. Consumers must accept a byte in every cycle where its valid is high.

Top module: `pon_preamble_splitter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `det_valid`, `steer_sel`, `pay_valid` and `chk_valid` are all 0.
- R2: The expected prefix is 0x55, 0x55, 0xD5, 0x55, 0x55, matched at burst positions 0 to 4. `det_valid` becomes 1 in the cycle after position 4 is accepted, provided all five bytes matched. It stays 1 until the cycle after `rx_valid` goes low. It stays 0 for the whole burst if any prefix byte differs.
- R3: The byte position clears to 0 whenever `rx_valid` is low, so the first valid byte after an idle cycle is position 0 of a new burst.
- R4: `steer_sel` is 0 while a byte at positions 0 to 7 is presented. It is 1 while a byte at position 8 or later is presented. It stays 1 for the rest of the burst, however long the burst is.
- R5: One cycle after a byte at position 8 or later is accepted, `pay_valid` is 1 and `pay_data` equals that byte unchanged. Bytes at positions 0 to 7 never appear on the payload port.
- R6: If `det_valid` is 1 when position 7 is accepted, then starting in the next cycle `chk_valid` is 1 for exactly five consecutive cycles. During those cycles `chk_data` carries the stored bytes of positions 2, 3, 4, 5 and 6, in that order. Position 2 is the delimiter; positions 5 and 6 are the link identifier.
- R7: `chk_last` is 1 only together with the fifth replayed byte (position 6).
- R8: No replay occurs for a burst whose prefix does not match, or for a burst shorter than 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte from the physical layer |
| rx_valid | input | 1 | High while a burst is being received |
| det_valid | output | 1 | Preamble prefix matched for the current burst |
| steer_sel | output | 1 | 0: current byte goes to the preamble buffer, 1: to the payload port |
| pay_data | output | 8 | Payload byte, one cycle after acceptance |
| pay_valid | output | 1 | Payload byte present |
| chk_data | output | 8 | Replayed header byte for the CRC checker |
| chk_valid | output | 1 | Replayed byte present |
| chk_last | output | 1 | Final replayed byte (second link-identifier byte) |

## Verification
The bench drives bursts with a correct prefix and bursts where one prefix byte is corrupted, including the delimiter alone. This separates a detector that compares every byte position from one that checks only some of them or checks them out of order. Burst lengths of 5, 7, 8 and 30 bytes cover three boundaries: detection without replay, the eighth byte that starts replay, and saturation of the steering select on long bursts. Random bursts with random lengths and payload contents confirm that replayed bytes come from the burst's own buffer slots in order. They also confirm that payload bytes pass through unchanged with one cycle of latency.

// File: rtl/pon_pre_pkg.sv
`timescale 1ns/1ps
package pon_pre_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned PRE_LEN  = 8;
  localparam int unsigned PFX_LEN  = 5;
  localparam int unsigned DELIM_AT = 2;
  localparam int unsigned LLID_END = 6;
  // prefix byte i sits at bits [i*8 +: 8]
  localparam logic [PFX_LEN*BYTE_W-1:0] PFX_BYTES = 40'h55_55_D5_55_55;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pre_pos_counter.sv
`timescale 1ns/1ps
module pre_pos_counter #(
  parameter int unsigned PRE_LEN = 8,
  localparam int unsigned CW = $clog2(PRE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  output logic [CW-1:0] pos,
  output logic          steer_sel
);
  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        pos_q <= '0;
    else if (!rx_valid)                pos_q <= '0;
    else if (pos_q != CW'(PRE_LEN))    pos_q <= pos_q + 1'b1;
  end

  assign pos       = pos_q;
  assign steer_sel = (pos_q == CW'(PRE_LEN));

  // R3: an idle cycle restarts the position
  a_r3_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (pos == '0));
  // R4: once steering to payload, stay there while the burst lasts
  a_r4_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_sel && rx_valid) |=> steer_sel);
endmodule

// File: rtl/pre_prefix_detect.sv
`timescale 1ns/1ps
module pre_prefix_detect #(
  parameter int unsigned DW      = 8,
  parameter int unsigned PFX_LEN = 5,
  parameter int unsigned CW      = 4,
  parameter logic [PFX_LEN*DW-1:0] PFX = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic [CW-1:0] pos,
  output logic          det_valid
);
  logic [PFX_LEN-1:0] slot_hit;
  logic               hit;
  logic               run_ok;
  logic               det_q;

  for (genvar i = 0; i < PFX_LEN; i++) begin : g_slot
    assign slot_hit[i] = (rx_data == PFX[i*DW +: DW]);
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < PFX_LEN; i++)
      if (pos == CW'(i)) hit = slot_hit[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_ok <= 1'b0;
      det_q  <= 1'b0;
    end else if (!rx_valid) begin
      run_ok <= 1'b0;
      det_q  <= 1'b0;
    end else if (pos == '0) begin
      run_ok <= hit;
    end else if (pos < CW'(PFX_LEN - 1)) begin
      run_ok <= run_ok & hit;
    end else if (pos == CW'(PFX_LEN - 1)) begin
      det_q  <= run_ok & hit;
    end
  end

  assign det_valid = det_q;

  // R2: detection only turns on right after the last prefix byte
  a_r2_rise_at_prefix_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_valid) |-> ($past(rx_valid) && $past(pos) == CW'(PFX_LEN - 1)));
  // R2: detection drops once the burst ends
  a_r2_drop_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !det_valid);
endmodule

// File: rtl/pre_park_replay.sv
`timescale 1ns/1ps
module pre_park_replay #(
  parameter int unsigned DW      = 8,
  parameter int unsigned PRE_LEN = 8,
  parameter int unsigned CW      = 4,
  parameter int unsigned FIRST   = 2,
  parameter int unsigned LAST    = 6,
  localparam int unsigned AW = $clog2(PRE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic [CW-1:0] pos,
  input  logic          steer_sel,
  input  logic          det_valid,
  output logic [DW-1:0] chk_data,
  output logic          chk_valid,
  output logic          chk_last
);
  logic [DW-1:0] park [PRE_LEN];
  logic [AW-1:0] rd_idx;
  logic          active;
  logic          start;

  always_ff @(posedge clk) begin
    if (rx_valid && !steer_sel) park[pos[AW-1:0]] <= rx_data;
  end

  assign start = rx_valid && det_valid && (pos == CW'(PRE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_idx <= '0;
    end else if (start) begin
      active <= 1'b1;
      rd_idx <= AW'(FIRST);
    end else if (active) begin
      if (rd_idx == AW'(LAST)) active <= 1'b0;
      else                     rd_idx <= rd_idx + 1'b1;
    end
  end

  assign chk_data  = park[rd_idx];
  assign chk_valid = active;
  assign chk_last  = active && (rd_idx == AW'(LAST));

  // R6: every replay begins at the delimiter slot
  a_r6_starts_at_delim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_valid) |-> (rd_idx == AW'(FIRST)));
  // R6: replay is contiguous until the last byte
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_last) |=> chk_valid);
  // R7: last flag only with a valid byte, and ends the replay
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    chk_last |=> !chk_valid);
  // R8: replay only follows a detected burst reaching the last preamble slot
  a_r8_needs_detect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_valid) |-> ($past(det_valid) && $past(rx_valid)));
endmodule

// File: rtl/pon_preamble_splitter.sv
`timescale 1ns/1ps
module pon_preamble_splitter
  import pon_pre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              det_valid,
  output logic              steer_sel,
  output logic [BYTE_W-1:0] pay_data,
  output logic              pay_valid,
  output logic [BYTE_W-1:0] chk_data,
  output logic              chk_valid,
  output logic              chk_last
);
  localparam int unsigned CW = $clog2(PRE_LEN + 1);

  logic [CW-1:0] pos;
  byte_t         pay_q;
  logic          pay_v_q;

  pre_pos_counter #(.PRE_LEN(PRE_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
    .pos(pos), .steer_sel(steer_sel)
  );

  pre_prefix_detect #(
    .DW(BYTE_W), .PFX_LEN(PFX_LEN), .CW(CW), .PFX(PFX_BYTES)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .pos(pos), .det_valid(det_valid)
  );

  pre_park_replay #(
    .DW(BYTE_W), .PRE_LEN(PRE_LEN), .CW(CW),
    .FIRST(DELIM_AT), .LAST(LLID_END)
  ) u_park (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .pos(pos), .steer_sel(steer_sel), .det_valid(det_valid),
    .chk_data(chk_data), .chk_valid(chk_valid), .chk_last(chk_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_v_q <= 1'b0;
      pay_q   <= '0;
    end else begin
      pay_v_q <= rx_valid && steer_sel;
      pay_q   <= rx_data;
    end
  end

  assign pay_data  = pay_q;
  assign pay_valid = pay_v_q;

  // R5: payload only follows a byte steered past the preamble
  a_r5_payload_source: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(rx_valid && steer_sel));
  // R5: payload carries the accepted byte unchanged
  a_r5_payload_same: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> (pay_data == $past(rx_data)));
endmodule

// File: tb/pon_preamble_splitter_bench.sv
`timescale 1ns/1ps
module pon_preamble_splitter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       det_valid, steer_sel, pay_valid, chk_valid, chk_last;
  logic [7:0] pay_data, chk_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] fb [0:31];
  int         rp_n;
  logic [7:0] rp_d [0:15];
  logic       rp_l [0:15];

  always #2.5 clk = ~clk;

  pon_preamble_splitter u_pon_preamble_splitter (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .det_valid(det_valid), .steer_sel(steer_sel),
    .pay_data(pay_data), .pay_valid(pay_valid),
    .chk_data(chk_data), .chk_valid(chk_valid), .chk_last(chk_last)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && chk_valid === 1'b1) begin
      if (rp_n < 16) begin
        rp_d[rp_n] = chk_data;
        rp_l[rp_n] = chk_last;
      end
      rp_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit prefix_ok(input int len);
    return len >= 5 && fb[0] == 8'h55 && fb[1] == 8'h55 && fb[2] == 8'hD5 &&
           fb[3] == 8'h55 && fb[4] == 8'h55;
  endfunction

  // outputs after the edge that accepted position q
  task automatic check_after(input int q, input int len);
    bit exp_det = prefix_ok(len) && q >= 4;
    chk(det_valid == exp_det, "R2 det_valid", int'(det_valid), int'(exp_det));
    chk(pay_valid == (q >= 8), "R5 pay_valid", int'(pay_valid), int'(q >= 8));
    if (q >= 8) chk(pay_data == fb[q], "R5 pay_data", int'(pay_data), int'(fb[q]));
  endtask

  task automatic run_frame(input int len);
    int exp_n;
    rp_n = 0;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      if (p > 0) check_after(p - 1, len);
      rx_valid = 1'b1;
      rx_data  = fb[p];
      chk(steer_sel == (p >= 8), "R4 steer_sel", int'(steer_sel), int'(p >= 8));
    end
    @(negedge clk);
    check_after(len - 1, len);
    rx_valid = 1'b0;
    rx_data  = 8'($urandom);
    @(negedge clk);
    chk(det_valid == 1'b0, "R2 det drop", int'(det_valid), 0);
    chk(steer_sel == 1'b0, "R3 position cleared", int'(steer_sel), 0);
    chk(pay_valid == 1'b0, "R5 no payload when idle", int'(pay_valid), 0);
    repeat (7) @(negedge clk);
    exp_n = (prefix_ok(len) && len >= 8) ? 5 : 0;
    chk(rp_n == exp_n, exp_n == 0 ? "R8 replay count" : "R6 replay count", rp_n, exp_n);
    if (rp_n == exp_n) begin
      for (int k = 0; k < exp_n; k++) begin
        chk(rp_d[k] == fb[2 + k], "R6 replay byte", int'(rp_d[k]), int'(fb[2 + k]));
        chk(rp_l[k] == (k == 4), "R7 last flag", int'(rp_l[k]), int'(k == 4));
      end
    end
  endtask

  task automatic fill(input bit good);
    for (int i = 0; i < 32; i++) fb[i] = 8'($urandom);
    if (good) begin
      fb[0] = 8'h55; fb[1] = 8'h55; fb[2] = 8'hD5; fb[3] = 8'h55; fb[4] = 8'h55;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00; rp_n = 0;
    repeat (3) @(negedge clk);
    chk(!det_valid && !steer_sel && !pay_valid && !chk_valid, "R1 reset outputs",
        int'({det_valid, steer_sel, pay_valid, chk_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!det_valid && !steer_sel && !pay_valid && !chk_valid, "R1 after release",
        int'({det_valid, steer_sel, pay_valid, chk_valid}), 0);

    fill(1'b1); run_frame(8);            // R6 exact preamble length
    fill(1'b1); run_frame(7);            // R8 one byte short
    fill(1'b1); run_frame(5);            // R2 prefix only
    fill(1'b1); fb[2] = 8'h55; run_frame(12);  // R2 R8 corrupted delimiter
    fill(1'b1); fb[0] = 8'hD5; run_frame(10);  // R2 first byte wrong
    fill(1'b1); fb[4] = 8'h54; run_frame(10);  // R2 last prefix byte wrong
    fill(1'b1); run_frame(30);           // R4 saturation on long burst
    fill(1'b1); run_frame(9);            // R3 restart after long burst

    for (int n = 0; n < 60; n++) begin
      int len = 1 + int'($urandom % 24);
      fill(($urandom % 4) != 0);
      if (($urandom % 4) == 0) begin
        int slot = int'($urandom % 5);
        fb[slot] = fb[slot] ^ (8'h01 << ($urandom % 8));
      end
      run_frame(len);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule